// File: doc/BRIEF.md
# Hierarchical Channel Interrupt Aggregator

This block gathers event flags from a set of host transfer channels and reduces them to one interrupt line through three levels of masking. Each channel keeps an 11-bit register of sticky event flags and an 11-bit enable register with the same layout. A per-channel pending bit is formed from those two. The pending bits of all channels form a summary word, which has its own enable word. The summary and a sticky port-change flag feed a two-bit core status word. That word is gated by a core enable word and by a single global enable bit to drive `irq_o`.

The upper levels hold no state. A summary bit, or a core status bit, drops only when the flags beneath it are cleared, or masked, at their own level. Writing a summary or core status register has no effect. Event sources (transaction engine, DMA, port logic) deliver single-cycle pulses. Software uses a 32-bit register port with a one-cycle registered read.

Register map (byte addresses, word aligned):
- 0x00: core status, read-only. Bit 0 is the channel bit, bit 1 is the port bit.
- 0x04: core enable, bits 1:0.
- 0x08: global enable, bit 0.
- 0x0C: port flag, bit 0, write-1-to-clear.
- 0x10: summary, read-only, bit c for channel c.
- 0x14: summary enable.
- 0x40 + 8*c: channel c event flags, bits 10:0, write-1-to-clear.
- 0x44 + 8*c: channel c enable, bits 10:0.

Top module: `chan_irq_aggregator`

## Requirements
- R1: A pulse on bit b of a channel's event input sets bit b of that channel's flag register at the next clock edge, whatever that channel's enable register holds. Flags stay set until cleared.
- R2: Writing the channel flag register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R3: If an event pulse and a write-1-to-clear hit the same flag bit in the same cycle, the bit ends up set.
- R4: After reset, every channel enable register, the summary enable, the core enable, the global enable, all flags and `irq_o` are 0.
- R5: Summary bit c is the OR over channel c's flags ANDed with its enable register. Writing the summary address changes nothing.
- R6: Core status bit 0 is 1 exactly when some summary bit is set whose summary enable bit is also 1. It clears only when the flags or enables beneath it are cleared.
- R7: Core status bit 1 follows the sticky port flag, which a port pulse sets and a write of 1 to bit 0 at 0x0C clears. Writing the core status address changes nothing.
- R8: `irq_o` is 1, one cycle after the state that causes it, only when the global enable is 1 and some core status bit is 1 with its core enable bit also 1.
- R9: Read data is captured at the clock edge where `bus_rd_i` is high. It holds until the next read.
- R10: Addresses in the channel window beyond the last implemented channel read as 0, and writes to them have no effect. The channel count is a parameter from 1 to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_evt_i | input | NUM_CH*EVT_W | Event pulses; channel c uses bits [c*EVT_W +: EVT_W] |
| port_evt_i | input | 1 | Port change pulse |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt line |

## Verification
Events are raised with every enable level off, so that flag latching is seen apart from interrupt generation. The enable levels are then switched on one at a time, and the line must rise only when the last one is on. Partial, zero and full clear patterns, and a clear that collides with a new event, tell write-1-to-clear apart from plain overwrite and show which side wins. Writes to the summary and core status addresses, and to an unimplemented channel, tell derived state apart from stored state.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int EVT_W_DEF   = 11;
  localparam int A_CORE_STS  = 'h00;
  localparam int A_CORE_EN   = 'h04;
  localparam int A_GLB_EN    = 'h08;
  localparam int A_PORT_FLAG = 'h0C;
  localparam int A_SUMMARY   = 'h10;
  localparam int A_SUM_EN    = 'h14;
  localparam int A_CH_BASE   = 'h40;
  localparam int CH_STRIDE_LG = 3;
  localparam int CORE_CH_BIT   = 0;
  localparam int CORE_PORT_BIT = 1;
endpackage

// File: rtl/irq_chan_slot.sv
module irq_chan_slot #(
  parameter int EVT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             flag_we_i,
  input  logic             en_we_i,
  input  logic [31:0]      wdata_i,
  output logic [EVT_W-1:0] flag_o,
  output logic [EVT_W-1:0] en_o,
  output logic             pend_o
);
  logic [EVT_W-1:0] flag_q;
  logic [EVT_W-1:0] en_q;
  logic [EVT_W-1:0] clr_bits;

  assign clr_bits = flag_we_i ? wdata_i[EVT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      // new events take priority over a simultaneous clear
      flag_q <= (flag_q & ~clr_bits) | evt_i;
      if (en_we_i) en_q <= wdata_i[EVT_W-1:0];
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign pend_o = |(flag_q & en_q);
endmodule

// File: rtl/irq_core_level.sv
module irq_core_level
  import irq_agg_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] summary_i,
  input  logic              port_evt_i,
  input  logic              sum_en_we_i,
  input  logic              core_en_we_i,
  input  logic              glb_we_i,
  input  logic              port_we_i,
  input  logic [31:0]       wdata_i,
  output logic [NUM_CH-1:0] sum_en_o,
  output logic [1:0]        core_en_o,
  output logic              glb_en_o,
  output logic              port_flag_o,
  output logic [1:0]        core_sts_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] sum_en_q;
  logic [1:0]        core_en_q;
  logic              glb_q;
  logic              port_q;
  logic              irq_q;
  logic [1:0]        core_sts;

  always_comb begin
    core_sts = '0;
    core_sts[CORE_CH_BIT]   = |(summary_i & sum_en_q);
    core_sts[CORE_PORT_BIT] = port_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_en_q  <= '0;
      core_en_q <= '0;
      glb_q     <= 1'b0;
      port_q    <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (sum_en_we_i)  sum_en_q  <= wdata_i[NUM_CH-1:0];
      if (core_en_we_i) core_en_q <= wdata_i[1:0];
      if (glb_we_i)     glb_q     <= wdata_i[0];
      port_q <= (port_q & ~(port_we_i & wdata_i[0])) | port_evt_i;
      irq_q  <= glb_q & (|(core_sts & core_en_q));
    end
  end

  assign sum_en_o    = sum_en_q;
  assign core_en_o   = core_en_q;
  assign glb_en_o    = glb_q;
  assign port_flag_o = port_q;
  assign core_sts_o  = core_sts;
  assign irq_o       = irq_q;
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_agg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int EVT_W  = 11,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_i,
  input  logic                    rd_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [NUM_CH*EVT_W-1:0] ch_flag_i,
  input  logic [NUM_CH*EVT_W-1:0] ch_en_i,
  input  logic [NUM_CH-1:0]       summary_i,
  input  logic [NUM_CH-1:0]       sum_en_i,
  input  logic [1:0]              core_sts_i,
  input  logic [1:0]              core_en_i,
  input  logic                    glb_en_i,
  input  logic                    port_flag_i,
  output logic [NUM_CH-1:0]       ch_flag_we_o,
  output logic [NUM_CH-1:0]       ch_en_we_o,
  output logic                    sum_en_we_o,
  output logic                    core_en_we_o,
  output logic                    glb_we_o,
  output logic                    port_we_o,
  output logic [31:0]             rdata_o
);
  localparam int IDX_W = ADDR_W - CH_STRIDE_LG;

  logic [ADDR_W-1:0] ch_off;
  logic [IDX_W-1:0]  ch_idx;
  logic              ch_hit;
  logic [31:0]       rd_val;
  logic [31:0]       rdata_q;

  always_comb begin
    ch_off = addr_i - ADDR_W'(A_CH_BASE);
    ch_idx = ch_off[ADDR_W-1:CH_STRIDE_LG];
    ch_hit = (addr_i >= ADDR_W'(A_CH_BASE)) && (32'(ch_idx) < NUM_CH);
  end

  assign sum_en_we_o  = wr_i && (addr_i == ADDR_W'(A_SUM_EN));
  assign core_en_we_o = wr_i && (addr_i == ADDR_W'(A_CORE_EN));
  assign glb_we_o     = wr_i && (addr_i == ADDR_W'(A_GLB_EN));
  assign port_we_o    = wr_i && (addr_i == ADDR_W'(A_PORT_FLAG));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_we
    assign ch_flag_we_o[c] = wr_i && ch_hit && (ch_idx == IDX_W'(c)) && !addr_i[2];
    assign ch_en_we_o[c]   = wr_i && ch_hit && (ch_idx == IDX_W'(c)) &&  addr_i[2];
  end

  always_comb begin
    rd_val = '0;
    if (ch_hit) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (ch_idx == IDX_W'(c)) begin
          rd_val[EVT_W-1:0] = addr_i[2] ? ch_en_i[c*EVT_W +: EVT_W]
                                        : ch_flag_i[c*EVT_W +: EVT_W];
        end
      end
    end else begin
      case (addr_i)
        ADDR_W'(A_CORE_STS):  rd_val[1:0]        = core_sts_i;
        ADDR_W'(A_CORE_EN):   rd_val[1:0]        = core_en_i;
        ADDR_W'(A_GLB_EN):    rd_val[0]          = glb_en_i;
        ADDR_W'(A_PORT_FLAG): rd_val[0]          = port_flag_i;
        ADDR_W'(A_SUMMARY):   rd_val[NUM_CH-1:0] = summary_i;
        ADDR_W'(A_SUM_EN):    rd_val[NUM_CH-1:0] = sum_en_i;
        default:              rd_val             = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/chan_irq_aggregator.sv
module chan_irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int EVT_W  = EVT_W_DEF,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH*EVT_W-1:0] chan_evt_i,
  input  logic                    port_evt_i,
  input  logic                    bus_wr_i,
  input  logic                    bus_rd_i,
  input  logic [ADDR_W-1:0]       bus_addr_i,
  input  logic [31:0]             bus_wdata_i,
  output logic [31:0]             bus_rdata_o,
  output logic                    irq_o
);
  logic [NUM_CH*EVT_W-1:0] ch_flag;
  logic [NUM_CH*EVT_W-1:0] ch_en;
  logic [NUM_CH-1:0]       summary;
  logic [NUM_CH-1:0]       ch_flag_we;
  logic [NUM_CH-1:0]       ch_en_we;
  logic [NUM_CH-1:0]       sum_en;
  logic [1:0]              core_en;
  logic [1:0]              core_sts;
  logic                    glb_en;
  logic                    port_flag;
  logic                    sum_en_we;
  logic                    core_en_we;
  logic                    glb_we;
  logic                    port_we;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    irq_chan_slot #(.EVT_W(EVT_W)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .evt_i     (chan_evt_i[c*EVT_W +: EVT_W]),
      .flag_we_i (ch_flag_we[c]),
      .en_we_i   (ch_en_we[c]),
      .wdata_i   (bus_wdata_i),
      .flag_o    (ch_flag[c*EVT_W +: EVT_W]),
      .en_o      (ch_en[c*EVT_W +: EVT_W]),
      .pend_o    (summary[c])
    );
  end

  irq_core_level #(.NUM_CH(NUM_CH)) u_core (
    .clk          (clk),
    .rst          (rst),
    .summary_i    (summary),
    .port_evt_i   (port_evt_i),
    .sum_en_we_i  (sum_en_we),
    .core_en_we_i (core_en_we),
    .glb_we_i     (glb_we),
    .port_we_i    (port_we),
    .wdata_i      (bus_wdata_i),
    .sum_en_o     (sum_en),
    .core_en_o    (core_en),
    .glb_en_o     (glb_en),
    .port_flag_o  (port_flag),
    .core_sts_o   (core_sts),
    .irq_o        (irq_o)
  );

  irq_reg_port #(.NUM_CH(NUM_CH), .EVT_W(EVT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .wr_i         (bus_wr_i),
    .rd_i         (bus_rd_i),
    .addr_i       (bus_addr_i),
    .ch_flag_i    (ch_flag),
    .ch_en_i      (ch_en),
    .summary_i    (summary),
    .sum_en_i     (sum_en),
    .core_sts_i   (core_sts),
    .core_en_i    (core_en),
    .glb_en_i     (glb_en),
    .port_flag_i  (port_flag),
    .ch_flag_we_o (ch_flag_we),
    .ch_en_we_o   (ch_en_we),
    .sum_en_we_o  (sum_en_we),
    .core_en_we_o (core_en_we),
    .glb_we_o     (glb_we),
    .port_we_o    (port_we),
    .rdata_o      (bus_rdata_o)
  );
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker #(
  parameter int NUM_CH = 8,
  parameter int EVT_W  = 11
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NUM_CH*EVT_W-1:0] chan_evt_i,
  input logic                    bus_wr_i,
  input logic                    irq_o,
  input logic [NUM_CH*EVT_W-1:0] ch_flag,
  input logic [NUM_CH*EVT_W-1:0] ch_en,
  input logic [NUM_CH-1:0]       sum_en,
  input logic [1:0]              core_en,
  input logic [1:0]              core_sts,
  input logic                    glb_en
);
  assert_evt_latched_R1: assert property (@(posedge clk) disable iff (rst)
    (|chan_evt_i) |=> ((ch_flag & $past(chan_evt_i)) == $past(chan_evt_i)));

  assert_no_clear_without_write_R2: assert property (@(posedge clk) disable iff (rst)
    !bus_wr_i |=> ((ch_flag & $past(ch_flag)) == $past(ch_flag)));

  assert_enables_reset_R4: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ch_en == '0 && sum_en == '0 && core_en == '0 && !glb_en && !irq_o));

  assert_core_ch_has_source_R6: assert property (@(posedge clk) disable iff (rst)
    core_sts[0] |-> (|(ch_flag & ch_en)));

  assert_irq_needs_global_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(glb_en));
endmodule

bind chan_irq_aggregator irq_agg_checker #(.NUM_CH(NUM_CH), .EVT_W(EVT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .chan_evt_i (chan_evt_i),
  .bus_wr_i   (bus_wr_i),
  .irq_o      (irq_o),
  .ch_flag    (ch_flag),
  .ch_en      (ch_en),
  .sum_en     (sum_en),
  .core_en    (core_en),
  .core_sts   (core_sts),
  .glb_en     (glb_en)
);

// File: tb/chan_irq_aggregator_test.sv
`timescale 1ns/1ps
module chan_irq_aggregator_test;
  localparam int NUM_CH = 8;
  localparam int EVT_W  = 11;
  localparam int ADDR_W = 8;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [NUM_CH*EVT_W-1:0] chan_evt = '0;
  logic                    port_evt = 1'b0;
  logic                    wr = 1'b0;
  logic                    rd = 1'b0;
  logic [ADDR_W-1:0]       addr = '0;
  logic [31:0]             wdata = '0;
  logic [31:0]             rdata;
  logic                    irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  chan_irq_aggregator #(.NUM_CH(NUM_CH), .EVT_W(EVT_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .chan_evt_i(chan_evt), .port_evt_i(port_evt),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [ADDR_W-1:0] flag_a(int c); return ADDR_W'('h40 + 8*c); endfunction
  function automatic logic [ADDR_W-1:0] en_a(int c);   return ADDR_W'('h44 + 8*c); endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic reg_wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic expect_rd(string req, logic [ADDR_W-1:0] a, logic [31:0] exp);
    logic [31:0] v;
    reg_rd(a, v);
    check(req, v, exp);
  endtask

  task automatic pulse_ch(int c, logic [EVT_W-1:0] bits);
    chan_evt[c*EVT_W +: EVT_W] = bits;
    @(posedge clk); @(negedge clk);
    chan_evt = '0;
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    check("R4 irq", 32'(irq), 0);
    expect_rd("R4 core status", 8'h00, 0);
    expect_rd("R4 core enable", 8'h04, 0);
    expect_rd("R4 global enable", 8'h08, 0);
    expect_rd("R4 summary enable", 8'h14, 0);
    expect_rd("R4 ch0 enable", en_a(0), 0);
    expect_rd("R4 ch7 enable", en_a(7), 0);
    expect_rd("R4 ch3 flags", flag_a(3), 0);
  endtask

  task automatic t_event_sets();
    pulse_ch(2, 11'h005);
    expect_rd("R1 ch2 flags", flag_a(2), 32'h005);
    pulse_ch(2, 11'h400);
    expect_rd("R1 ch2 sticky", flag_a(2), 32'h405);
    expect_rd("R5 summary masked", 8'h10, 0);
    check("R1 irq stays low", 32'(irq), 0);
  endtask

  task automatic t_w1c();
    reg_wr(flag_a(2), 32'h001);
    expect_rd("R2 partial clear", flag_a(2), 32'h404);
    reg_wr(flag_a(2), 32'h000);
    expect_rd("R2 zero write", flag_a(2), 32'h404);
    reg_wr(flag_a(2), 32'h7FF);
    expect_rd("R2 full clear", flag_a(2), 0);
  endtask

  task automatic t_set_wins();
    pulse_ch(5, 11'h030);
    expect_rd("R1 ch5 flags", flag_a(5), 32'h030);
    chan_evt[5*EVT_W +: EVT_W] = 11'h010;
    reg_wr(flag_a(5), 32'h030);
    chan_evt = '0;
    expect_rd("R3 set beats clear", flag_a(5), 32'h010);
  endtask

  task automatic t_summary();
    reg_wr(en_a(5), 32'h001);
    expect_rd("R5 non-matching enable", 8'h10, 0);
    reg_wr(en_a(5), 32'h010);
    expect_rd("R5 summary bit", 8'h10, 32'h20);
    reg_wr(8'h10, 32'hFF);
    expect_rd("R5 summary write ignored", 8'h10, 32'h20);
    expect_rd("R6 core masked by summary enable", 8'h00, 0);
  endtask

  task automatic t_enable_chain();
    logic [31:0] v;
    reg_wr(8'h14, 32'h20);
    expect_rd("R6 core channel bit", 8'h00, 32'h1);
    check("R8 no core enable", 32'(irq), 0);
    reg_wr(8'h04, 32'h1);
    settle();
    check("R8 no global enable", 32'(irq), 0);
    reg_wr(8'h08, 32'h1);
    check("R8 one cycle latency", 32'(irq), 0);
    settle();
    check("R8 all levels on", 32'(irq), 1);
    reg_rd(8'h00, v);
    reg_wr(8'h00, 32'h3);
    expect_rd("R7 core write ignored", 8'h00, 32'h1);
    check("R9 read held", rdata, 32'h1);
    reg_wr(8'h14, 32'h00);
    settle();
    check("R8 summary enable off", 32'(irq), 0);
    reg_wr(8'h14, 32'h20);
    settle();
    check("R8 summary enable on", 32'(irq), 1);
    reg_wr(flag_a(5), 32'h010);
    expect_rd("R6 cleared from below", 8'h00, 0);
    check("R8 irq drops", 32'(irq), 0);
  endtask

  task automatic t_port();
    port_evt = 1'b1; settle(); port_evt = 1'b0;
    expect_rd("R7 port bit", 8'h00, 32'h2);
    check("R8 port not enabled", 32'(irq), 0);
    reg_wr(8'h04, 32'h3);
    settle();
    check("R8 port enabled", 32'(irq), 1);
    reg_wr(8'h00, 32'h2);
    expect_rd("R7 core write no clear", 8'h00, 32'h2);
    reg_wr(8'h0C, 32'h1);
    expect_rd("R7 port cleared", 8'h00, 0);
    check("R8 port irq drops", 32'(irq), 0);
  endtask

  task automatic t_range();
    logic [31:0] v;
    reg_rd(flag_a(5), v);
    reg_wr(flag_a(NUM_CH), 32'h7FF);
    reg_wr(en_a(NUM_CH), 32'h7FF);
    check("R9 hold without read", rdata, v);
    expect_rd("R10 absent flags", flag_a(NUM_CH), 0);
    expect_rd("R10 absent enable", en_a(NUM_CH), 0);
    expect_rd("R10 ch7 enable untouched", en_a(NUM_CH-1), 0);
    expect_rd("R10 ch0 enable untouched", en_a(0), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_event_sets();
    t_w1c();
    t_set_wins();
    t_summary();
    t_enable_chain();
    t_port();
    t_range();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule